// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a multiply and multiply-accumulate engine that software drives through a 16-bit register port. The port has a byte address, a write strobe, write data and a combinational read path. Two engines share the port.

The first engine multiplies two 16-bit operands into a 32-bit result. The address that receives the first operand picks one of four modes: unsigned multiply, signed multiply, unsigned accumulate or signed accumulate. Writing the second operand starts the operation. In the accumulate modes, two running sums are kept side by side. One adds the zero-extended product and the other adds the sign-extended product. The result register then takes the sum that matches the mode.

The second engine multiplies two 32-bit operands into a 64-bit result, as either an unsigned or a signed multiply. Each operand is written as two halves. The write to the upper half of the second operand starts the multiply. The product is read back as four 16-bit words. Both multipliers are combinational, so each result is registered on the clock edge of the write that starts it.

Top module: `mac_periph`

## Requirements
- R1: A synchronous active-high reset clears every operand, result and accumulator register to zero, selects unsigned 16x16 multiply, and selects unsigned 32x32 multiply.
- R2: 32x32 operand writes use these byte offsets: 0x00 (operand-1 low half, also selects unsigned 32x32), 0x04 (operand-1 low half, also selects signed 32x32), 0x02 (operand-1 high half), 0x10 (operand-2 low half) and 0x12 (operand-2 high half). The write to 0x12 starts the 32x32 multiply, and its result is readable in the cycle after that write.
- R3: The 64-bit result is read as 16-bit words at 0x14, 0x16, 0x18 and 0x1A, least significant word first.
- R4: Unsigned 32x32 mode zero-extends both operands. For example, 0xFFFFFFFC times 0x00000002 gives the words 0xFFF8, 0xFFFF, 0x0001 and 0x0000.
- R5: Signed 32x32 mode sign-extends both operands to 64 bits before multiplying.
- R6: A 16x16 operand-1 write selects the mode by its address: 0x06 unsigned multiply, 0x08 signed multiply, 0x0A unsigned accumulate, 0x0C signed accumulate. The mode stays latched until the next operand-1 write. A write to 0x0E stores operand 2 and starts the operation. The 32-bit result is read at 0x1C (low) and 0x1E (high).
- R7: Signed 16x16 multiply sign-extends both operands, and the result holds the two's-complement pattern of the product.
- R8: Each non-accumulating 16x16 operation clears both running sums to zero.
- R9: Each accumulate operation does three things: it adds the zero-extended product to the unsigned sum (read at 0x24/0x26), it adds the sign-extended product to the signed sum (read at 0x20/0x22), and it loads the result register with the sum that matches the mode. All sums wrap modulo 2^32.
- R10: Result and sum registers are read-only. A write to them has no effect, and they change only when an operation starts.
- R11: A read from an unmapped word address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address; bit 0 is ignored |
| we | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |

## Verification
The in-line assertions check every cycle that the result and sum registers stay unchanged unless an operation starts (R10). They also check that a non-accumulating 16x16 operation leaves both sums at zero (R8), and that after an accumulate the result register equals the sum that matches the mode (R9). The product values themselves can only be shown by the bench scenarios. These cover the zero-extension case 0xFFFFFFFC times 2, the signed 32x32 products, a mode that stays latched across two accumulate triggers, and the two sums drifting apart as signed and unsigned products are mixed.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int WORD_W = 16;
    localparam int DWORD_W = 2 * WORD_W;
    localparam int QWORD_W = 4 * WORD_W;

    // byte offsets of the register words
    localparam int OFF_OP1L_U = 'h00;
    localparam int OFF_OP1H = 'h02;
    localparam int OFF_OP1L_S = 'h04;
    localparam int OFF_A_UMUL = 'h06;
    localparam int OFF_A_SMUL = 'h08;
    localparam int OFF_A_UMAC = 'h0A;
    localparam int OFF_A_SMAC = 'h0C;
    localparam int OFF_B16 = 'h0E;
    localparam int OFF_OP2L = 'h10;
    localparam int OFF_OP2H = 'h12;
    localparam int OFF_P64_0 = 'h14;
    localparam int OFF_P64_1 = 'h16;
    localparam int OFF_P64_2 = 'h18;
    localparam int OFF_P64_3 = 'h1A;
    localparam int OFF_R32_L = 'h1C;
    localparam int OFF_R32_H = 'h1E;
    localparam int OFF_SSUM_L = 'h20;
    localparam int OFF_SSUM_H = 'h22;
    localparam int OFF_USUM_L = 'h24;
    localparam int OFF_USUM_H = 'h26;

    typedef enum logic [1:0] {
        M_UMUL = 2'd0,
        M_SMUL = 2'd1,
        M_UMAC = 2'd2,
        M_SMAC = 2'd3
    } mode16_e;

    typedef struct packed {
        logic wr_a32_u;
        logic wr_a32_s;
        logic wr_a32_hi;
        logic wr_b32_lo;
        logic go32;
        logic wr_a16;
        mode16_e a16_mode;
        logic go16;
        logic res_wr;
    } dec_t;

    typedef struct packed {
        logic [DWORD_W-1:0] a32;
        logic [WORD_W-1:0] b32_lo;
        logic sgn32;
        logic [QWORD_W-1:0] p64;
        logic [WORD_W-1:0] a16;
        logic [WORD_W-1:0] b16;
        mode16_e mode;
        logic [DWORD_W-1:0] r32;
        logic [DWORD_W-1:0] usum;
        logic [DWORD_W-1:0] ssum;
    } state_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output dec_t              dec
);

    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0] widx;

    function automatic logic hit(input logic [IDX_W-1:0] w, input int off);
        return w == IDX_W'(off >> 1);
    endfunction

    always_comb begin
        widx = addr[ADDR_W-1:1];
        dec = '0;
        dec.a16_mode = M_UMUL;
        if (we) begin
            dec.wr_a32_u = hit(widx, OFF_OP1L_U);
            dec.wr_a32_s = hit(widx, OFF_OP1L_S);
            dec.wr_a32_hi = hit(widx, OFF_OP1H);
            dec.wr_b32_lo = hit(widx, OFF_OP2L);
            dec.go32 = hit(widx, OFF_OP2H);
            dec.go16 = hit(widx, OFF_B16);
            if (hit(widx, OFF_A_UMUL)) begin
                dec.wr_a16 = 1'b1;
                dec.a16_mode = M_UMUL;
            end else if (hit(widx, OFF_A_SMUL)) begin
                dec.wr_a16 = 1'b1;
                dec.a16_mode = M_SMUL;
            end else if (hit(widx, OFF_A_UMAC)) begin
                dec.wr_a16 = 1'b1;
                dec.a16_mode = M_UMAC;
            end else if (hit(widx, OFF_A_SMAC)) begin
                dec.wr_a16 = 1'b1;
                dec.a16_mode = M_SMAC;
            end
            dec.res_wr = hit(widx, OFF_P64_0) || hit(widx, OFF_P64_1)
                      || hit(widx, OFF_P64_2) || hit(widx, OFF_P64_3)
                      || hit(widx, OFF_R32_L) || hit(widx, OFF_R32_H)
                      || hit(widx, OFF_SSUM_L) || hit(widx, OFF_SSUM_H)
                      || hit(widx, OFF_USUM_L) || hit(widx, OFF_USUM_H);
        end
    end

endmodule

// File: rtl/mac_widen_mul.sv
module mac_widen_mul #(
    parameter int IN_W = 16
) (
    input  logic [IN_W-1:0]   a,
    input  logic [IN_W-1:0]   b,
    input  logic              sgn,
    output logic [2*IN_W-1:0] prod
);

    localparam int OUT_W = 2 * IN_W;

    logic [OUT_W-1:0] ext_a;
    logic [OUT_W-1:0] ext_b;

    // both operands are widened to the full product width first; the low
    // OUT_W bits of that product are correct for either interpretation
    always_comb begin
        ext_a = sgn ? {{IN_W{a[IN_W-1]}}, a} : {{IN_W{1'b0}}, a};
        ext_b = sgn ? {{IN_W{b[IN_W-1]}}, b} : {{IN_W{1'b0}}, b};
        prod = ext_a * ext_b;
    end

endmodule

// File: rtl/mac_periph.sv
module mac_periph
    import mac_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);

    localparam int IDX_W = ADDR_W - 1;

    dec_t dec;
    state_t st_q;
    state_t st_d;

    logic [DWORD_W-1:0] b32_full;
    logic [QWORD_W-1:0] p64_d;
    logic [DWORD_W-1:0] pz16_d;
    logic [DWORD_W-1:0] ps16_d;
    logic [DWORD_W-1:0] usum_nx;
    logic [DWORD_W-1:0] ssum_nx;
    logic [IDX_W-1:0] ridx;

    mac_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(addr),
        .we(we),
        .dec(dec)
    );

    assign b32_full = {wdata, st_q.b32_lo};

    mac_widen_mul #(.IN_W(DWORD_W)) u_mul32 (
        .a(st_q.a32),
        .b(b32_full),
        .sgn(st_q.sgn32),
        .prod(p64_d)
    );

    mac_widen_mul #(.IN_W(WORD_W)) u_mul16_z (
        .a(st_q.a16),
        .b(wdata),
        .sgn(1'b0),
        .prod(pz16_d)
    );

    mac_widen_mul #(.IN_W(WORD_W)) u_mul16_s (
        .a(st_q.a16),
        .b(wdata),
        .sgn(1'b1),
        .prod(ps16_d)
    );

    always_comb begin
        st_d = st_q;
        usum_nx = st_q.usum + pz16_d;
        ssum_nx = st_q.ssum + ps16_d;

        if (dec.wr_a32_u) begin
            st_d.a32[WORD_W-1:0] = wdata;
            st_d.sgn32 = 1'b0;
        end
        if (dec.wr_a32_s) begin
            st_d.a32[WORD_W-1:0] = wdata;
            st_d.sgn32 = 1'b1;
        end
        if (dec.wr_a32_hi) st_d.a32[DWORD_W-1:WORD_W] = wdata;
        if (dec.wr_b32_lo) st_d.b32_lo = wdata;
        if (dec.go32) st_d.p64 = p64_d;

        if (dec.wr_a16) begin
            st_d.a16 = wdata;
            st_d.mode = dec.a16_mode;
        end
        if (dec.go16) begin
            st_d.b16 = wdata;
            unique case (st_q.mode)
                M_UMUL: begin
                    st_d.r32 = pz16_d;
                    st_d.usum = '0;
                    st_d.ssum = '0;
                end
                M_SMUL: begin
                    st_d.r32 = ps16_d;
                    st_d.usum = '0;
                    st_d.ssum = '0;
                end
                M_UMAC: begin
                    st_d.usum = usum_nx;
                    st_d.ssum = ssum_nx;
                    st_d.r32 = usum_nx;
                end
                default: begin
                    st_d.usum = usum_nx;
                    st_d.ssum = ssum_nx;
                    st_d.r32 = ssum_nx;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ridx = addr[ADDR_W-1:1];
        unique case (ridx)
            IDX_W'(OFF_OP1L_U >> 1): rdata = st_q.a32[WORD_W-1:0];
            IDX_W'(OFF_OP1L_S >> 1): rdata = st_q.a32[WORD_W-1:0];
            IDX_W'(OFF_OP1H >> 1):   rdata = st_q.a32[DWORD_W-1:WORD_W];
            IDX_W'(OFF_A_UMUL >> 1): rdata = st_q.a16;
            IDX_W'(OFF_A_SMUL >> 1): rdata = st_q.a16;
            IDX_W'(OFF_A_UMAC >> 1): rdata = st_q.a16;
            IDX_W'(OFF_A_SMAC >> 1): rdata = st_q.a16;
            IDX_W'(OFF_B16 >> 1):    rdata = st_q.b16;
            IDX_W'(OFF_OP2L >> 1):   rdata = st_q.b32_lo;
            IDX_W'(OFF_P64_0 >> 1):  rdata = st_q.p64[15:0];
            IDX_W'(OFF_P64_1 >> 1):  rdata = st_q.p64[31:16];
            IDX_W'(OFF_P64_2 >> 1):  rdata = st_q.p64[47:32];
            IDX_W'(OFF_P64_3 >> 1):  rdata = st_q.p64[63:48];
            IDX_W'(OFF_R32_L >> 1):  rdata = st_q.r32[15:0];
            IDX_W'(OFF_R32_H >> 1):  rdata = st_q.r32[31:16];
            IDX_W'(OFF_SSUM_L >> 1): rdata = st_q.ssum[15:0];
            IDX_W'(OFF_SSUM_H >> 1): rdata = st_q.ssum[31:16];
            IDX_W'(OFF_USUM_L >> 1): rdata = st_q.usum[15:0];
            IDX_W'(OFF_USUM_H >> 1): rdata = st_q.usum[31:16];
            default:                 rdata = '0;
        endcase
    end

    // R10
    p64_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dec.go32 |=> $stable(st_q.p64));

    // R10
    r32_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dec.go16 |=> ($stable(st_q.r32) && $stable(st_q.usum) && $stable(st_q.ssum)));

    // R8
    plain_clears_sums_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.go16 && (st_q.mode == M_UMUL || st_q.mode == M_SMUL))
        |=> (st_q.usum == '0 && st_q.ssum == '0));

    // R9
    umac_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.go16 && st_q.mode == M_UMAC) |=> (st_q.r32 == st_q.usum));

    // R9
    smac_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.go16 && st_q.mode == M_SMAC) |=> (st_q.r32 == st_q.ssum));

    // R10
    res_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        dec.res_wr |=> ($stable(st_q.p64) && $stable(st_q.r32)));

endmodule

// File: tb/sim_mac_periph.sv
module sim_mac_periph;

    typedef struct {
        logic [5:0] a;
        logic [15:0] exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0] drv_addr = '0;
    logic [5:0] mon_addr = '0;
    logic mon_own = 1'b0;
    logic [5:0] addr;
    logic we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    item_t sb[$];
    logic busy = 1'b0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    assign addr = mon_own ? mon_addr : drv_addr;

    always #10 clk = ~clk;

    mac_periph #(.ADDR_W(6)) u0 (
        .clk(clk),
        .rst(rst),
        .addr(addr),
        .we(we),
        .wdata(wdata),
        .rdata(rdata)
    );

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        drv_addr = a;
        wdata = d;
        we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic expect16(input logic [5:0] a, input logic [15:0] e, input string t);
        item_t it;
        it.a = a;
        it.exp = e;
        it.tag = t;
        sb.push_back(it);
    endtask

    task automatic expect64(input logic [63:0] v, input string t);
        expect16(6'h14, v[15:0], t);
        expect16(6'h16, v[31:16], t);
        expect16(6'h18, v[47:32], t);
        expect16(6'h1A, v[63:48], t);
    endtask

    task automatic expect32(input logic [5:0] a, input logic [31:0] v, input string t);
        expect16(a, v[15:0], t);
        expect16(a + 6'd2, v[31:16], t);
    endtask

    task automatic drain();
        wait (sb.size() == 0 && busy == 1'b0);
    endtask

    // monitor: pops expected items and compares them against the read port
    initial begin
        item_t it;
        forever begin
            wait (sb.size() > 0);
            busy = 1'b1;
            it = sb.pop_front();
            @(negedge clk);
            mon_addr = it.a;
            mon_own = 1'b1;
            #2;
            n_run++;
            if (rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
            end
            mon_own = 1'b0;
            busy = 1'b0;
        end
    end

    initial begin
        logic [63:0] e64;
        logic [31:0] us;
        logic [31:0] ss;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything cleared by reset
        expect64(64'h0, "R1");
        expect32(6'h1C, 32'h0, "R1");
        expect32(6'h20, 32'h0, "R1");
        expect32(6'h24, 32'h0, "R1");
        drain();

        // R2 R3 R4: unsigned 32x32, no sign extension of the operands
        wr(6'h00, 16'h0002);
        wr(6'h02, 16'h0000);
        wr(6'h10, 16'hFFFC);
        wr(6'h12, 16'hFFFF);
        e64 = 64'h0000_0000_FFFF_FFFC * 64'h2;
        expect64(e64, "R4");
        expect16(6'h14, 16'hFFF8, "R3");
        expect16(6'h18, 16'h0001, "R3");
        drain();

        // R5: signed 32x32, 2 * -4
        wr(6'h04, 16'h0002);
        wr(6'h02, 16'h0000);
        wr(6'h10, 16'hFFFC);
        wr(6'h12, 16'hFFFF);
        expect64(64'hFFFF_FFFF_FFFF_FFF8, "R5");
        drain();

        // R5: signed 32x32, (-3) * (-5)
        wr(6'h04, 16'hFFFD);
        wr(6'h02, 16'hFFFF);
        wr(6'h10, 16'hFFFB);
        wr(6'h12, 16'hFFFF);
        expect64(64'd15, "R5");
        drain();

        // R10: writes to result words are ignored
        wr(6'h14, 16'h1234);
        wr(6'h1A, 16'hABCD);
        wr(6'h1C, 16'h5555);
        expect64(64'd15, "R10");
        expect32(6'h1C, 32'h0, "R10");
        drain();

        // R6: unsigned 16x16 multiply
        wr(6'h06, 16'hFFFF);
        wr(6'h0E, 16'hFFFF);
        expect32(6'h1C, 32'hFFFE_0001, "R6");
        drain();

        // R7 R8: signed 16x16, -1 * 2
        wr(6'h08, 16'hFFFF);
        wr(6'h0E, 16'h0002);
        expect32(6'h1C, 32'hFFFF_FFFE, "R7");
        expect32(6'h20, 32'h0, "R8");
        expect32(6'h24, 32'h0, "R8");
        drain();

        // R9: unsigned accumulate, mode stays latched for a second trigger (R6)
        us = 32'hFFFF * 32'd2;
        ss = 32'hFFFF_FFFE;
        wr(6'h0A, 16'hFFFF);
        wr(6'h0E, 16'h0002);
        expect32(6'h1C, us, "R9");
        expect32(6'h24, us, "R9");
        expect32(6'h20, ss, "R9");
        drain();
        us = us + 32'hFFFF * 32'd3;
        ss = ss - 32'd3;
        wr(6'h0E, 16'h0003);
        expect32(6'h1C, us, "R6");
        expect32(6'h20, ss, "R9");
        drain();

        // R9: signed accumulate, -1 * -1
        us = us + 32'hFFFE_0001;
        ss = ss + 32'd1;
        wr(6'h0C, 16'hFFFF);
        wr(6'h0E, 16'hFFFF);
        expect32(6'h1C, ss, "R9");
        expect32(6'h24, us, "R9");
        expect32(6'h20, ss, "R9");
        drain();

        // R8: plain multiply clears both sums
        wr(6'h06, 16'h0001);
        wr(6'h0E, 16'h0001);
        expect32(6'h1C, 32'h1, "R8");
        expect32(6'h20, 32'h0, "R8");
        expect32(6'h24, 32'h0, "R8");
        drain();

        // R11: unmapped words read zero
        expect16(6'h30, 16'h0, "R11");
        expect16(6'h3E, 16'h0, "R11");
        drain();

        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule